// File: doc/BRIEF.md
# I2C Slave Transmitter with Event Status Codes

This block is the read-side half of a two-wire serial slave. It watches SDA and SCL through synchronizers and recognizes START and STOP conditions. It matches its own 7-bit address when the direction bit asks for a read, then shifts data bytes onto the bus that a host writes into a data register. Every protocol event raises an interrupt flag and latches a fixed 8-bit code into a status register. While the flag is up, the block holds SCL low, so the master waits until the host has serviced the event.

The host talks to three registers. The control register has acknowledge-enable, a stop request and a flag-clear bit; the flag clears when a one is written to that bit. The data register holds the next byte to send. The status register reads 0xF8 whenever the flag is clear. A START or STOP that lands inside a byte or its acknowledge slot is a bus error with code 0x00. The host recovers by writing the stop bit and the flag-clear bit together. This returns the block to the not-addressed state with both lines released, and no STOP is driven onto the bus.

A neighbouring master can pulse an arbitration-lost input. If the block is then addressed for a read, it reports that case with its own code.

Top module: `i2c_slave_tx`

## Requirements
- R1: When an address byte arrives whose upper seven bits (sent MSB first) equal `own_addr_i` and whose last bit is 1 (read), and acknowledge-enable is set, the block pulls SDA low during the ninth clock. After the ninth falling edge it sets the flag with status 0xA8.
- R2: If `arb_lost_i` pulsed since the last STOP, the same address event reports status 0xB0 instead of 0xA8.
- R3: After the flag is cleared, the byte in the data register is driven MSB first, with SDA changing only while SCL is low. A master ACK (SDA low on the ninth clock) with acknowledge-enable set at load time gives status 0xB8, and further bytes can follow.
- R4: A master NACK (SDA high on the ninth clock) after a data byte gives status 0xC0. Once the flag is cleared, the block is not addressed and leaves SDA released for any further clocks.
- R5: If acknowledge-enable was clear when a byte was loaded and the master still ACKs it, the status is 0xC8. Once the flag is cleared, further reads return all ones and raise no flag.
- R6: While the flag is clear, the status output reads 0xF8.
- R7: While the flag is set, `scl_oe_o` is asserted. A control write with the clear bit at 1 clears the flag, and a control write with the clear bit at 0 leaves the flag set.
- R8: A START or STOP seen after at least one SCL rising edge of an address or data frame (including the acknowledge clock) sets the flag with status 0x00 and releases SDA.
- R9: A control write with both the stop bit and the clear bit at 1 clears the flag. On the next cycle SDA and SCL are released, the stop bit reads 0, acknowledge-enable keeps its written value and the block is not addressed. A stop bit written without the clear bit reads back as 1.
- R10: No acknowledge and no flag are produced for a different address, for the write direction (last bit 0), or when acknowledge-enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| own_addr_i | input | 7 | Own slave address |
| arb_lost_i | input | 1 | Pulse from a master: arbitration was lost |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_ack_en_i | input | 1 | Acknowledge-enable write value |
| ctl_stop_i | input | 1 | Stop bit write value |
| ctl_clr_i | input | 1 | Flag-clear bit (write 1 to clear) |
| dat_wr_i | input | 1 | Data register write strobe |
| dat_i | input | 8 | Data register write value |
| ack_en_o | output | 1 | Acknowledge-enable readback |
| stop_o | output | 1 | Stop bit readback |
| flag_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code |

## Verification
The hardest cases to reach are the bus errors. A START or STOP must occur with SCL high while a frame is partly shifted. For a data byte, this also requires that the slave is not holding SDA low at that moment. The bench's bit-level master stops partway through an address (after three bits) and partway through an all-ones data byte (after four bits), then raises SCL and toggles SDA. It first writes the stop bit alone and then together with the clear bit, to show that the stop bit clears by itself. The 0xC8 path needs acknowledge-enable cleared in the same write that releases the final byte, followed by a master ACK and a further read.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 2);

  typedef logic [7:0] code_t;
  localparam code_t CODE_ADDR = 8'hA8;
  localparam code_t CODE_ARB  = 8'hB0;
  localparam code_t CODE_ACK  = 8'hB8;
  localparam code_t CODE_NACK = 8'hC0;
  localparam code_t CODE_LAST = 8'hC8;
  localparam code_t CODE_NONE = 8'hF8;
  localparam code_t CODE_BERR = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_TX, ST_WAIT, ST_LOAD, ST_ERR
  } st_e;
endpackage

// File: rtl/i2c_stx_sync.sv
module i2c_stx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;  // idle bus is high
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_stx_regs.sv
module i2c_stx_regs
  import i2c_stx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic              ctl_ack_en_i,
  input  logic              ctl_stop_i,
  input  logic              ctl_clr_i,
  input  logic              dat_wr_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              set_i,
  input  code_t             code_i,
  output logic              ack_en_o,
  output logic              stop_o,
  output logic              flag_o,
  output code_t             status_o,
  output logic [DATA_W-1:0] dat_o,
  output logic              clr_evt_o,
  output logic              recover_o
);
  code_t code_q;

  assign clr_evt_o = ctl_wr_i & ctl_clr_i & flag_o;
  assign recover_o = ctl_wr_i & ctl_clr_i & ctl_stop_i;
  assign status_o  = flag_o ? code_q : CODE_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_en_o <= 1'b0;
      stop_o   <= 1'b0;
      flag_o   <= 1'b0;
      code_q   <= CODE_NONE;
      dat_o    <= '0;
    end else begin
      if (ctl_wr_i) ack_en_o <= ctl_ack_en_i;
      if (recover_o)     stop_o <= 1'b0;
      else if (ctl_wr_i) stop_o <= ctl_stop_i;
      if (recover_o)      flag_o <= 1'b0;
      else if (set_i)     flag_o <= 1'b1;
      else if (clr_evt_o) flag_o <= 1'b0;
      if (set_i) code_q <= code_i;
      if (dat_wr_i) dat_o <= dat_i;
    end
  end
endmodule

// File: rtl/i2c_stx_fsm.sv
module i2c_stx_fsm
  import i2c_stx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              arb_lost_i,
  input  logic              ack_en_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              clr_evt_i,
  input  logic              recover_i,
  output logic              set_o,
  output code_t             code_o,
  output logic              scl_hold_o,
  output logic              sda_oe_o
);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] C_ACK  = CNT_W'(DATA_W + 1);

  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic scl_d, sda_d, ack_drv_q, tx_act_q, mack_q, last_q, nxt_load_q, arb_q, hold_q;
  logic rise, fall, start_c, stop_c, in_frame, match;

  assign rise     = scl_s_i & ~scl_d;
  assign fall     = ~scl_s_i & scl_d;
  assign start_c  = scl_s_i & scl_d & sda_d & ~sda_s_i;
  assign stop_c   = scl_s_i & scl_d & ~sda_d & sda_s_i;
  assign in_frame = (st_q == ST_ADDR) || (st_q == ST_TX);
  assign match    = (sh_q[DATA_W-1:1] == own_addr_i) && sh_q[0] && ack_en_i;

  assign sda_oe_o   = ack_drv_q | (tx_act_q & ~sh_q[DATA_W-1]);
  assign scl_hold_o = (st_q == ST_LOAD) | hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0;
      scl_d <= 1'b1; sda_d <= 1'b1;
      ack_drv_q <= 1'b0; tx_act_q <= 1'b0; mack_q <= 1'b0; last_q <= 1'b0;
      nxt_load_q <= 1'b0; arb_q <= 1'b0; hold_q <= 1'b0;
      set_o <= 1'b0; code_o <= CODE_NONE;
    end else begin
      scl_d  <= scl_s_i;
      sda_d  <= sda_s_i;
      set_o  <= 1'b0;
      hold_q <= (st_q == ST_LOAD) && !recover_i;
      if (arb_lost_i) arb_q <= 1'b1;
      if (recover_i) begin
        st_q <= ST_IDLE; cnt_q <= '0; ack_drv_q <= 1'b0; tx_act_q <= 1'b0;
      end else if (in_frame && (start_c || stop_c) && cnt_q != '0) begin
        st_q <= ST_ERR; set_o <= 1'b1; code_o <= CODE_BERR;
        ack_drv_q <= 1'b0; tx_act_q <= 1'b0;
      end else if (start_c && (in_frame || st_q == ST_IDLE)) begin
        st_q <= ST_ADDR; cnt_q <= '0; tx_act_q <= 1'b0; ack_drv_q <= 1'b0;
      end else if (stop_c && (in_frame || st_q == ST_IDLE)) begin
        st_q <= ST_IDLE; arb_q <= 1'b0; tx_act_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (rise) begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q < C_LAST) sh_q <= {sh_q[DATA_W-2:0], sda_s_i};
            end else if (fall && cnt_q == C_LAST) begin
              if (match) ack_drv_q <= 1'b1;
              else       st_q <= ST_IDLE;
            end else if (fall && cnt_q == C_ACK) begin
              ack_drv_q  <= 1'b0;
              st_q       <= ST_WAIT;
              set_o      <= 1'b1;
              code_o     <= arb_q ? CODE_ARB : CODE_ADDR;
              arb_q      <= 1'b0;
              nxt_load_q <= 1'b1;
              cnt_q      <= '0;
            end
          end
          ST_TX: begin
            if (rise) begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == C_LAST) mack_q <= ~sda_s_i;
            end else if (fall && cnt_q != '0 && cnt_q < C_LAST) begin
              sh_q <= {sh_q[DATA_W-2:0], 1'b1};
            end else if (fall && cnt_q == C_LAST) begin
              tx_act_q <= 1'b0;
            end else if (fall && cnt_q == C_ACK) begin
              st_q       <= ST_WAIT;
              set_o      <= 1'b1;
              cnt_q      <= '0;
              code_o     <= !mack_q ? CODE_NACK : (last_q ? CODE_LAST : CODE_ACK);
              nxt_load_q <= mack_q & ~last_q;
            end
          end
          ST_WAIT: if (clr_evt_i) st_q <= nxt_load_q ? ST_LOAD : ST_IDLE;
          ST_LOAD: begin
            sh_q <= dat_i; last_q <= ~ack_en_i; tx_act_q <= 1'b1;
            cnt_q <= '0; st_q <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
  import i2c_stx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              arb_lost_i,
  input  logic              ctl_wr_i,
  input  logic              ctl_ack_en_i,
  input  logic              ctl_stop_i,
  input  logic              ctl_clr_i,
  input  logic              dat_wr_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              ack_en_o,
  output logic              stop_o,
  output logic              flag_o,
  output logic [7:0]        status_o
);
  logic scl_s, sda_s, set, clr_evt, recover, scl_hold;
  code_t code;
  logic [DATA_W-1:0] dat_q;

  i2c_stx_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s));
  i2c_stx_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s));

  i2c_stx_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ctl_wr_i(ctl_wr_i), .ctl_ack_en_i(ctl_ack_en_i), .ctl_stop_i(ctl_stop_i),
    .ctl_clr_i(ctl_clr_i), .dat_wr_i(dat_wr_i), .dat_i(dat_i),
    .set_i(set), .code_i(code),
    .ack_en_o(ack_en_o), .stop_o(stop_o), .flag_o(flag_o), .status_o(status_o),
    .dat_o(dat_q), .clr_evt_o(clr_evt), .recover_o(recover));

  i2c_stx_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .own_addr_i(own_addr_i), .arb_lost_i(arb_lost_i), .ack_en_i(ack_en_o),
    .dat_i(dat_q), .clr_evt_i(clr_evt), .recover_i(recover),
    .set_o(set), .code_o(code), .scl_hold_o(scl_hold), .sda_oe_o(sda_oe_o));

  assign scl_oe_o = flag_o | scl_hold;
endmodule

// File: rtl/i2c_stx_chk.sv
module i2c_stx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       ctl_wr_i,
  input logic       ctl_stop_i,
  input logic       ctl_clr_i,
  input logic       stop_o,
  input logic       flag_o,
  input logic [7:0] status_o
);
  p_stretch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> scl_oe_o);

  p_no_info_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_o |-> status_o == 8'hF8);

  p_recover_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && ctl_stop_i && ctl_clr_i) |=> (!stop_o && !flag_o && !sda_oe_o && !scl_oe_o));

  // legal codes while flagged, bus error code included (R8)
  p_legal_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> (status_o == 8'hA8 || status_o == 8'hB0 || status_o == 8'hB8 ||
                status_o == 8'hC0 || status_o == 8'hC8 || status_o == 8'h00));

  p_flag_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(ctl_wr_i && ctl_clr_i));
endmodule

bind i2c_slave_tx i2c_stx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
  .ctl_wr_i(ctl_wr_i), .ctl_stop_i(ctl_stop_i), .ctl_clr_i(ctl_clr_i),
  .stop_o(stop_o), .flag_o(flag_o), .status_o(status_o));

// File: tb/i2c_slave_tx_tb_top.sv
module i2c_slave_tx_tb_top;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic arb_lost = 1'b0, ctl_wr = 1'b0, ctl_ae = 1'b0, ctl_st = 1'b0, ctl_cl = 1'b0;
  logic dat_wr = 1'b0;
  logic [7:0] dat = '0;
  logic scl_oe, sda_oe, ack_en, stop_b, flag;
  logic [7:0] status;
  wire scl_bus = ~(scl_oe | m_scl_lo);
  wire sda_bus = ~(sda_oe | m_sda_lo);

  i2c_slave_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(OWN), .arb_lost_i(arb_lost),
    .ctl_wr_i(ctl_wr), .ctl_ack_en_i(ctl_ae), .ctl_stop_i(ctl_st), .ctl_clr_i(ctl_cl),
    .dat_wr_i(dat_wr), .dat_i(dat), .ack_en_o(ack_en), .stop_o(stop_b),
    .flag_o(flag), .status_o(status));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string exp_tag[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_code(string req, logic [7:0] c);
    exp_q.push_back(c);
    exp_tag.push_back(req);
  endtask

  // monitor: every flag rise pops an expected status code
  logic flag_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && flag && !flag_prev) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL unexpected flag: actual %0h expected none", status);
      end else begin
        check(exp_tag.pop_front(), status, exp_q.pop_front());
      end
    end
    flag_prev <= flag;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic hq(); repeat (Q) @(negedge clk); endtask
  task automatic wait_high(); while (!scl_bus) @(negedge clk); endtask

  task automatic m_start();
    m_sda_lo = 0; hq(); m_scl_lo = 0; wait_high(); hq();
    m_sda_lo = 1; hq(); m_scl_lo = 1; hq();
  endtask
  task automatic m_stop();
    m_sda_lo = 1; hq(); m_scl_lo = 0; wait_high(); hq(); m_sda_lo = 0; hq();
  endtask
  task automatic wbit(logic b);
    m_sda_lo = !b; hq(); m_scl_lo = 0; wait_high(); hq(); hq(); m_scl_lo = 1; hq();
  endtask
  task automatic rbit(output logic b);
    m_sda_lo = 0; hq(); m_scl_lo = 0; wait_high(); hq(); b = sda_bus; hq(); m_scl_lo = 1; hq();
  endtask
  task automatic m_addr(logic [6:0] a, logic rw, output logic ack);
    logic b;
    for (int i = 6; i >= 0; i--) wbit(a[i]);
    wbit(rw);
    rbit(b);
    ack = !b;
    repeat (4) @(negedge clk);
  endtask
  task automatic m_read(logic macks, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(!macks);
    repeat (4) @(negedge clk);
  endtask

  task automatic host_ctl(logic ae, logic st, logic cl);
    @(negedge clk); ctl_wr = 1; ctl_ae = ae; ctl_st = st; ctl_cl = cl;
    @(negedge clk); ctl_wr = 0; ctl_cl = 0; ctl_st = 0;
    @(negedge clk);
  endtask
  task automatic serve(logic [7:0] d, logic ae);
    @(negedge clk); dat_wr = 1; dat = d;
    @(negedge clk); dat_wr = 0;
    host_ctl(ae, 0, 1);
  endtask

  initial begin
    logic ack;
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R6 reset status", status, 8'hF8);
    check("R7 reset flag", flag, 0);
    check("R7 reset scl_oe", scl_oe, 0);
    check("R9 reset stop", stop_b, 0);

    // R1/R3/R4: normal read of two bytes ending with NACK
    host_ctl(1, 0, 0);
    expect_code("R1 address read", 8'hA8);
    m_start(); m_addr(OWN, 1, ack);
    check("R1 address ack", ack, 1);
    check("R7 scl stretched", scl_bus, 0);
    host_ctl(1, 0, 0);
    check("R7 write of 0 keeps flag", flag, 1);
    serve(8'hA5, 1);
    check("R7 clear flag", flag, 0);
    check("R6 status after clear", status, 8'hF8);
    expect_code("R3 byte acked", 8'hB8);
    m_read(1, rd);
    check("R3 first byte msb first", rd, 8'hA5);
    serve(8'h3C, 1);
    expect_code("R4 byte nacked", 8'hC0);
    m_read(0, rd);
    check("R3 second byte", rd, 8'h3C);
    host_ctl(1, 0, 1);
    m_read(1, rd);
    check("R4 not addressed reads ones", rd, 8'hFF);
    check("R4 no flag after", flag, 0);
    m_stop();

    // R5: last byte with ack enable cleared, master still acks
    expect_code("R1 address read", 8'hA8);
    m_start(); m_addr(OWN, 1, ack);
    serve(8'h81, 0);
    expect_code("R5 last byte acked", 8'hC8);
    m_read(1, rd);
    check("R5 last byte data", rd, 8'h81);
    host_ctl(1, 0, 1);
    m_read(1, rd);
    check("R5 further read all ones", rd, 8'hFF);
    check("R5 no flag after", flag, 0);
    m_stop();

    // R10: no acknowledge cases
    m_start(); m_addr(7'h15, 1, ack);
    check("R10 wrong address nack", ack, 0);
    check("R10 wrong address no flag", flag, 0);
    m_stop();
    m_start(); m_addr(OWN, 0, ack);
    check("R10 write direction nack", ack, 0);
    m_stop();
    host_ctl(0, 0, 0);
    m_start(); m_addr(OWN, 1, ack);
    check("R10 ack enable clear nack", ack, 0);
    check("R10 ack enable clear no flag", flag, 0);
    m_stop();
    host_ctl(1, 0, 0);

    // R2: arbitration lost then addressed
    @(negedge clk); arb_lost = 1; @(negedge clk); arb_lost = 0;
    expect_code("R2 arbitration lost", 8'hB0);
    m_start(); m_addr(OWN, 1, ack);
    check("R2 address ack", ack, 1);
    serve(8'h5A, 1);
    expect_code("R4 byte nacked", 8'hC0);
    m_read(0, rd);
    check("R2 byte after arbitration", rd, 8'h5A);
    host_ctl(1, 0, 1);
    m_stop();

    // R8/R9: STOP inside an address byte
    m_start();
    wbit(OWN[6]); wbit(OWN[5]); wbit(OWN[4]);
    expect_code("R8 stop in address", 8'h00);
    m_sda_lo = 1; hq(); m_scl_lo = 0; wait_high(); hq();
    m_sda_lo = 0; hq(); hq();
    check("R8 flag set", flag, 1);
    check("R8 sda released", sda_oe, 0);
    m_scl_lo = 1;
    host_ctl(1, 1, 0);
    check("R9 stop bit reads 1", stop_b, 1);
    check("R9 flag kept", flag, 1);
    host_ctl(1, 1, 1);
    check("R9 flag cleared", flag, 0);
    check("R9 stop bit self cleared", stop_b, 0);
    check("R9 ack enable kept", ack_en, 1);
    check("R9 scl released", scl_oe, 0);
    check("R9 sda released", sda_oe, 0);
    m_scl_lo = 0; hq();
    m_stop();

    // R8/R9: repeated START inside a data byte, then recovery and reuse
    expect_code("R1 address read", 8'hA8);
    m_start(); m_addr(OWN, 1, ack);
    serve(8'hFF, 1);
    for (int i = 0; i < 4; i++) rbit(ack);
    expect_code("R8 start in data", 8'h00);
    m_sda_lo = 0; hq(); m_scl_lo = 0; wait_high(); hq();
    m_sda_lo = 1; hq(); hq();
    check("R8 data error flag", flag, 1);
    m_scl_lo = 1;
    host_ctl(1, 1, 1);
    check("R9 recovered flag", flag, 0);
    check("R9 recovered status", status, 8'hF8);
    m_scl_lo = 0; hq();
    m_stop();
    expect_code("R9 usable after recovery", 8'hA8);
    m_start(); m_addr(OWN, 1, ack);
    check("R9 address ack after recovery", ack, 1);
    serve(8'h96, 1);
    expect_code("R4 byte nacked", 8'hC0);
    m_read(0, rd);
    check("R3 byte after recovery", rd, 8'h96);
    host_ctl(1, 0, 1);
    m_stop();

    repeat (20) @(negedge clk);
    check("R1 all expected events seen", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule